// File: doc/BRIEF.md
# Accumulator ALU with Link Bit and Single-Step Shifter

This block is the arithmetic core of a small microcoded accumulator machine. In one clock cycle it applies one of sixteen operations to an X operand and a Y operand. It then forms a link bit, and can move the result one place left or right with the link bit entering the vacated end. Any small constant the microcode wants to use arrives already steered onto the X operand. The final result and four internal condition bits (negative, zero, overflow, carry) come out combinationally. The microsequencer uses them for two-way branches, and the datapath writes the result wherever the microinstruction directs.

A four-bit flags register holds the machine-visible condition codes, with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. It copies the internal condition bits at a clock edge only when the flag-load input is high. Choosing operands and writing the result to a destination register are handled outside this block.

Top module: `alu_shift_unit`

## Requirements
- R1: Operation codes 0 (X), 1 (Y), 4 (X AND Y), 5 (X OR Y), 6 (X XOR Y), 7 (NOT Y), 10 (X AND 1), 11 (Y AND 1), 13 (NOT X), 14 (all ones) and 15 (zero) produce that value, with ALU carry out 0 and overflow 0.
- R2: Operation codes 2 (X+Y), 3 (X+Y+1), 8 (X+1) and 9 (Y+1) produce the sum modulo 256. Carry out is the ninth bit of the unsigned sum, and overflow is set when the two's-complement sum falls outside -128..127.
- R3: Operation code 12 computes Y + NOT X + 1, which is Y minus X. Carry out is 1 exactly when Y >= X unsigned, and overflow is set when the signed difference Y-X falls outside -128..127.
- R4: Link control 00 makes the link bit equal to bit 7 of the ALU value, 01 makes it 0, 10 makes it 1, and 11 makes it equal to the ALU carry out.
- R5: Shift control 01 gives {link, alu[7:1]}, and the carry bit becomes alu[0].
- R6: Shift control 10 gives {alu[6:0], link}, and the carry bit becomes alu[7].
- R7: Shift control 11 behaves exactly like shift control 00: the result is the ALU value and the carry bit is the ALU carry out.
- R8: N equals bit 7 of the final result, Z is 1 exactly when the final 8-bit result is zero, and V is the ALU overflow whatever the shift.
- R9: When flag_ld is 1 at a rising clock edge, the flags output holds {N,Z,V,C} from that cycle starting on the next cycle.
- R10: When flag_ld is 0 at a rising clock edge, the flags output keeps its value.
- R11: A rising edge with rst_n low clears the flags register to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flags register |
| x_in | input | 8 | X operand, or a constant placed on it |
| y_in | input | 8 | Y operand |
| op | input | 4 | Operation code 0..15 |
| lnk_ctl | input | 2 | Link bit control |
| sh_ctl | input | 2 | Shift control |
| flag_ld | input | 1 | Load the flags register this cycle |
| result | output | 8 | Final shifted result |
| n_int | output | 1 | Internal negative bit |
| z_int | output | 1 | Internal zero bit |
| v_int | output | 1 | Internal overflow bit |
| c_int | output | 1 | Internal carry bit |
| flags | output | 4 | Registered {N,Z,V,C} |

## Verification
All sixteen operation codes are swept against every link and shift setting, with X and Y each taken from sixteen corner values. These values include 0x00, 0x01, 0x7F, 0x80, 0xFF and alternating patterns. The 0x7F and 0x80 operands separate signed overflow from unsigned carry, for example in 0x80+0x80 and in 0x7F+1. The alternating and nibble patterns show a misrouted bit in a logic operation or a wrong shift direction. The all-ones and all-zero operands give the carry-driven link values, both cases of Y >= X in the subtraction, and zero-result detection after a shift. Separate clocked sequences load, hold and reset the flags register.

// File: rtl/alu_pkg.sv
// Shared widths and encodings for the accumulator ALU.
// Assumes an 8-bit data path unless the user overrides DATA_W.
package alu_pkg;
    parameter int DATA_W = 8;
    localparam int OP_W   = 4;
    localparam int CTL_W  = 2;
    localparam int FLAG_W = 4;

    // Operation codes; values are fixed by the microinstruction encoding.
    typedef enum logic [OP_W-1:0] {
        OP_PASSX = 4'd0,  OP_PASSY = 4'd1,  OP_ADD   = 4'd2,  OP_ADDC  = 4'd3,
        OP_AND   = 4'd4,  OP_OR    = 4'd5,  OP_XOR   = 4'd6,  OP_NOTY  = 4'd7,
        OP_INCX  = 4'd8,  OP_INCY  = 4'd9,  OP_X1    = 4'd10, OP_Y1    = 4'd11,
        OP_RSUB  = 4'd12, OP_NOTX  = 4'd13, OP_ONES  = 4'd14, OP_ZERO  = 4'd15
    } alu_op_e;

    // Link bit source selection.
    typedef enum logic [CTL_W-1:0] {
        LNK_KEEP  = 2'd0,
        LNK_CLR   = 2'd1,
        LNK_SET   = 2'd2,
        LNK_CARRY = 2'd3
    } lnk_ctl_e;

    // Shifter step selection; code 3 acts as no shift.
    typedef enum logic [CTL_W-1:0] {
        SH_NONE  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_LEFT  = 2'd2,
        SH_SPARE = 2'd3
    } sh_ctl_e;

    // Bit positions inside the flags register.
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;
endpackage

// File: rtl/alu_core.sv
// Combinational arithmetic/logic stage.
// One shared adder serves all add-type codes; logic codes report
// carry and overflow as zero. Assumes W >= 2.
module alu_core
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]    x_i,
    input  logic [W-1:0]    y_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o,
    output logic            c_o,
    output logic            v_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] add_a;
    logic [W-1:0] add_b;
    logic         add_ci;
    logic         is_arith;
    logic [W:0]   sum;

    // Pick the adder operands and carry-in for the add-type codes.
    always_comb begin
        add_a    = '0;
        add_b    = '0;
        add_ci   = 1'b0;
        is_arith = 1'b1;
        case (alu_op_e'(op_i))
            OP_ADD:  begin add_a = x_i;  add_b = y_i; end
            OP_ADDC: begin add_a = x_i;  add_b = y_i; add_ci = 1'b1; end
            OP_INCX: begin add_a = x_i;  add_ci = 1'b1; end
            OP_INCY: begin add_a = y_i;  add_ci = 1'b1; end
            OP_RSUB: begin add_a = ~x_i; add_b = y_i; add_ci = 1'b1; end
            default: is_arith = 1'b0;
        endcase
    end

    assign sum = {1'b0, add_a} + {1'b0, add_b} + {{W{1'b0}}, add_ci};

    // Select the operation value.
    always_comb begin
        case (alu_op_e'(op_i))
            OP_PASSX: res_o = x_i;
            OP_PASSY: res_o = y_i;
            OP_AND:   res_o = x_i & y_i;
            OP_OR:    res_o = x_i | y_i;
            OP_XOR:   res_o = x_i ^ y_i;
            OP_NOTY:  res_o = ~y_i;
            OP_X1:    res_o = x_i & ONE;
            OP_Y1:    res_o = y_i & ONE;
            OP_NOTX:  res_o = ~x_i;
            OP_ONES:  res_o = '1;
            OP_ZERO:  res_o = '0;
            default:  res_o = sum[W-1:0];
        endcase
    end

    // Carry and signed overflow, only meaningful for add-type codes.
    always_comb begin
        c_o = is_arith & sum[W];
        v_o = is_arith & (add_a[W-1] == add_b[W-1]) & (sum[W-1] != add_a[W-1]);
    end
endmodule

// File: rtl/alu_link_shift.sv
// Link bit formation and one-position shifter, followed by the
// internal condition bits. Purely combinational; assumes W >= 2.
module alu_link_shift
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]     alu_i,
    input  logic             alu_c_i,
    input  logic             alu_v_i,
    input  logic [CTL_W-1:0] lnk_i,
    input  logic [CTL_W-1:0] sh_i,
    output logic [W-1:0]     res_o,
    output logic             n_o,
    output logic             z_o,
    output logic             v_o,
    output logic             c_o
);
    logic link;

    // Choose the link bit value.
    always_comb begin
        case (lnk_ctl_e'(lnk_i))
            LNK_CLR:   link = 1'b0;
            LNK_SET:   link = 1'b1;
            LNK_CARRY: link = alu_c_i;
            default:   link = alu_i[W-1];
        endcase
    end

    // Apply the shift and route the displaced bit to carry.
    always_comb begin
        case (sh_ctl_e'(sh_i))
            SH_RIGHT: begin res_o = {link, alu_i[W-1:1]}; c_o = alu_i[0];   end
            SH_LEFT:  begin res_o = {alu_i[W-2:0], link}; c_o = alu_i[W-1]; end
            default:  begin res_o = alu_i;                c_o = alu_c_i;    end
        endcase
    end

    // Condition bits taken from the final value.
    always_comb begin
        n_o = res_o[W-1];
        z_o = ~|res_o;
        v_o = alu_v_i;
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Machine-visible condition code register. Loads {N,Z,V,C} when
// enabled; synchronous active-low reset clears it.
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              v_i,
    input  logic              c_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] next_flags;

    // Pack the incoming bits into register order.
    always_comb begin
        next_flags        = '0;
        next_flags[FLG_N] = n_i;
        next_flags[FLG_Z] = z_i;
        next_flags[FLG_V] = v_i;
        next_flags[FLG_C] = c_i;
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    flags_o <= '0;
        else if (ld_i) flags_o <= next_flags;
    end
endmodule

// File: rtl/alu_shift_unit.sv
// Top of the accumulator ALU: operation stage, link/shift stage and
// flags register. Operand selection and destinations live outside.
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      x_in,
    input  logic [W-1:0]      y_in,
    input  logic [OP_W-1:0]   op,
    input  logic [CTL_W-1:0]  lnk_ctl,
    input  logic [CTL_W-1:0]  sh_ctl,
    input  logic              flag_ld,
    output logic [W-1:0]      result,
    output logic              n_int,
    output logic              z_int,
    output logic              v_int,
    output logic              c_int,
    output logic [FLAG_W-1:0] flags
);
    logic [W-1:0] alu_val;
    logic         alu_c;
    logic         alu_v;

    alu_core #(.W(W)) u_core (
        .x_i   (x_in),
        .y_i   (y_in),
        .op_i  (op),
        .res_o (alu_val),
        .c_o   (alu_c),
        .v_o   (alu_v)
    );

    alu_link_shift #(.W(W)) u_shift (
        .alu_i   (alu_val),
        .alu_c_i (alu_c),
        .alu_v_i (alu_v),
        .lnk_i   (lnk_ctl),
        .sh_i    (sh_ctl),
        .res_o   (result),
        .n_o     (n_int),
        .z_o     (z_int),
        .v_o     (v_int),
        .c_o     (c_int)
    );

    alu_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_i    (flag_ld),
        .n_i     (n_int),
        .z_i     (z_int),
        .v_i     (v_int),
        .c_i     (c_int),
        .flags_o (flags)
    );
endmodule

// File: rtl/alu_shift_unit_chk.sv
// Property checker for alu_shift_unit, attached through bind.
module alu_shift_unit_chk
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op,
    input logic [CTL_W-1:0]  lnk_ctl,
    input logic [CTL_W-1:0]  sh_ctl,
    input logic              flag_ld,
    input logic [W-1:0]      result,
    input logic              n_int,
    input logic              z_int,
    input logic              v_int,
    input logic              c_int,
    input logic [FLAG_W-1:0] flags
);
    // R1: logic codes never report overflow when unshifted
    p_logic_no_v_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOTX) |-> !v_int);

    // R1: the zero code yields zero result and Z when not shifted
    p_zero_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ZERO && sh_ctl == SH_NONE) |-> (result == '0 && z_int && !c_int));

    // R6: a set link enters bit 0 on a left shift
    p_shl_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_ctl == SH_LEFT && lnk_ctl == LNK_SET) |-> result[0]);

    // R5: a cleared link enters bit 7 on a right shift
    p_shr_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_ctl == SH_RIGHT && lnk_ctl == LNK_CLR) |-> !result[W-1]);

    // R9: a load captures the internal bits
    p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_ld |=> flags == $past({n_int, z_int, v_int, c_int}));

    // R10: without a load the flags hold
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_ld |=> $stable(flags));

    // R11: reset clears the flags
    p_flag_reset_r11: assert property (@(posedge clk)
        !rst_n |=> flags == '0);
endmodule

bind alu_shift_unit alu_shift_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .lnk_ctl (lnk_ctl),
    .sh_ctl  (sh_ctl),
    .flag_ld (flag_ld),
    .result  (result),
    .n_int   (n_int),
    .z_int   (z_int),
    .v_int   (v_int),
    .c_int   (c_int),
    .flags   (flags)
);

// File: tb/alu_shift_unit_bench.sv
module alu_shift_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] x_in = '0;
    logic [7:0] y_in = '0;
    logic [3:0] op = '0;
    logic [1:0] lnk_ctl = '0;
    logic [1:0] sh_ctl = '0;
    logic       flag_ld = 1'b0;
    logic [7:0] result;
    logic       n_int, z_int, v_int, c_int;
    logic [3:0] flags;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    alu_shift_unit u_alu_shift_unit (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .op(op),
        .lnk_ctl(lnk_ctl), .sh_ctl(sh_ctl), .flag_ld(flag_ld),
        .result(result), .n_int(n_int), .z_int(z_int), .v_int(v_int),
        .c_int(c_int), .flags(flags)
    );

    function automatic logic [7:0] corner(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h7E;
            4: return 8'h7F;  5: return 8'h80;  6: return 8'h81;  7: return 8'hFE;
            8: return 8'hFF;  9: return 8'h55; 10: return 8'hAA; 11: return 8'h0F;
           12: return 8'hF0; 13: return 8'h3C; 14: return 8'hC3; default: return 8'h40;
        endcase
    endfunction

    // Reference: returns {result, N, Z, V, C}
    function automatic logic [11:0] model(input logic [7:0] x, input logic [7:0] y,
                                          input int o, input int lk, input int sh);
        int ux = x; int uy = y;
        int sx = $signed(x); int sy = $signed(y);
        int s = 0; int sv = 0;
        logic [7:0] r = '0; logic [7:0] f; logic c = 0; logic v = 0; logic l;
        logic arith = 1'b1;
        case (o)
            2:  begin s = ux + uy;           sv = sx + sy;     end
            3:  begin s = ux + uy + 1;       sv = sx + sy + 1; end
            8:  begin s = ux + 1;            sv = sx + 1;      end
            9:  begin s = uy + 1;            sv = sy + 1;      end
            12: begin s = uy + (255 - ux) + 1; sv = sy - sx;   end
            default: arith = 1'b0;
        endcase
        if (arith) begin
            r = s[7:0]; c = (s > 255); v = (sv > 127) || (sv < -128);
        end else begin
            case (o)
                0: r = x;        1: r = y;        4: r = x & y;   5: r = x | y;
                6: r = x ^ y;    7: r = ~y;       10: r = x & 8'h01; 11: r = y & 8'h01;
                13: r = ~x;      14: r = 8'hFF;   default: r = 8'h00;
            endcase
        end
        case (lk)
            0: l = r[7]; 1: l = 1'b0; 2: l = 1'b1; default: l = c;
        endcase
        f = r;
        if (sh == 1) begin f = {l, r[7:1]}; c = r[0]; end
        else if (sh == 2) begin f = {r[6:0], l}; c = r[7]; end
        return {f, f[7], (f == 8'h00), v, c};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (2) @(negedge clk);
        check("R11 reset flags", 32'(flags), 32'h0);
        rst_n = 1'b1;

        // Combinational sweep: R1 R2 R3 (ops), R4 (link), R5 R6 R7 (shift), R8 (N/Z/V)
        for (int o = 0; o < 16; o++)
            for (int lk = 0; lk < 4; lk++)
                for (int sh = 0; sh < 4; sh++)
                    for (int i = 0; i < 16; i++)
                        for (int j = 0; j < 16; j++) begin
                            string tag;
                            logic [11:0] exp;
                            x_in = corner(i); y_in = corner(j);
                            op = 4'(o); lnk_ctl = 2'(lk); sh_ctl = 2'(sh);
                            #1;
                            exp = model(x_in, y_in, o, lk, sh);
                            if (sh == 1) tag = "R5";
                            else if (sh == 2) tag = "R6";
                            else if (sh == 3) tag = "R7";
                            else if (o == 12) tag = "R3";
                            else if (o == 2 || o == 3 || o == 8 || o == 9) tag = "R2";
                            else tag = "R1";
                            tag = $sformatf("%s R4 R8 op=%0d lnk=%0d sh=%0d x=%h y=%h",
                                            tag, o, lk, sh, x_in, y_in);
                            check(tag, 32'({result, n_int, z_int, v_int, c_int}), 32'(exp));
                        end

        // R9: load flags from 0x80+0x80 -> N0 Z1 V1 C1
        @(negedge clk);
        x_in = 8'h80; y_in = 8'h80; op = 4'd2; lnk_ctl = 2'd0; sh_ctl = 2'd0; flag_ld = 1'b1;
        @(negedge clk);
        check("R9 load 80+80", 32'(flags), 32'h7);

        // R10: hold while different inputs present
        flag_ld = 1'b0; op = 4'd14;
        repeat (2) @(negedge clk);
        check("R10 hold", 32'(flags), 32'h7);

        // R9: load all ones -> N1 Z0 V0 C0
        flag_ld = 1'b1;
        @(negedge clk);
        check("R9 load ones", 32'(flags), 32'h8);

        // R9: right shift of 0x01 with cleared link -> zero, carry 1
        x_in = 8'h01; op = 4'd0; lnk_ctl = 2'd1; sh_ctl = 2'd1;
        @(negedge clk);
        check("R9 load shifted", 32'(flags), 32'h5);

        // R11: synchronous reset mid-run clears flags
        flag_ld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears", 32'(flags), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 hold after reset", 32'(flags), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule